// File: doc/BRIEF.md
# Sub-band coded serial port

This block moves MPEG layer 1 coded data over a three-wire serial link (bit clock, word select, data) plus a byte error flag. Each word-select period carries one 32-bit slot. The low half of the period carries slot bits 0 to 15 and the high half carries bits 16 to 31. Each half has 32 bit-clock positions, and only 16 of them carry data. The first data bit of each half sits in the position that follows the word-select edge.

When encoding, the port is the link master. It divides its own clock down to a bit clock whose period is set by a rate selector. It then shifts out slots taken from a one-deep holding register, which is filled through a valid/ready handshake. When decoding, the port is a slave. It oversamples the external bit clock, word select, data and error flag through a synchronizer. It rebuilds each slot and hands it out with four per-byte error flags on a valid/ready output. A direction input can keep the output drivers released even while encoding. The port models this with a driver-enable output beside the three driven lines.

Top module: `subband_serial_port`

## Requirements
- R1: While reset is held, the port drives bit clock high, word select high, data low, tx_ready high, rx_valid low and drv_en_o low (with enc_mode low).
- R2: In encode mode the bit-clock period in system-clock cycles is 8, 12, 16 or 24 for rate_sel codes 0, 1, 2 and 3. Half of each period is low and half is high.
- R3: In encode mode, word select and data change only on the system-clock edge where the bit clock falls. Word select is low for 32 bit-clock periods and then high for 32.
- R4: Transmit layout: the first position of each half carries no data. Positions 1 to 16 of the low half carry slot bits 0 to 15 in ascending order, and positions 1 to 16 of the high half carry bits 16 to 31. The other 32 positions are driven low.
- R5: tx_ready is high while the holding register is empty and drops on the cycle after a word is accepted. The accepted word is sent in the next word-select period that starts after acceptance, and the register empties at that start. A period that starts with the register empty carries an all-zero slot.
- R6: drv_en_o is high only when enc_mode is high and dir_hold is low.
- R7: In decode mode the port samples the synchronized inputs on each rising edge of the external bit clock. A word-select change marks position 0 of a half, and data is mapped as in R4 with the unused positions ignored. While encoding, the receiver never raises rx_valid.
- R8: rx_err[k] is the error input sampled at slot bit 8k+4, for k = 0 to 3. The error input at every other position is ignored.
- R9: A slot is presented on rx_data/rx_err with rx_valid once bit 31 is captured. It is held stable until rx_ready is high. A slot that completes while an earlier one is still waiting is discarded.
- R10: A slot is delivered only if a falling word-select edge was seen since reset or since the last completed slot. A high half received without a preceding low-half start yields nothing.
- R11: In decode mode the master outputs park at bit clock high, word select high and data low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the master clock for division |
| rst_n | input | 1 | Active-low synchronous reset |
| enc_mode | input | 1 | 1 = encode (master transmit), 0 = decode (slave receive) |
| dir_hold | input | 1 | 1 keeps the line drivers released |
| rate_sel | input | 2 | Bit-clock period select (0:8, 1:12, 2:16, 3:24 cycles) |
| sb_bclk_i | input | 1 | External bit clock (decode) |
| sb_ws_i | input | 1 | External word select (decode) |
| sb_sd_i | input | 1 | External serial data (decode) |
| sb_err_i | input | 1 | External byte error flag (decode) |
| sb_bclk_o | output | 1 | Generated bit clock (encode) |
| sb_ws_o | output | 1 | Generated word select (encode) |
| sb_sd_o | output | 1 | Serial data out (encode) |
| drv_en_o | output | 1 | Enable for the bit clock, word select and data drivers |
| tx_data | input | 32 | Slot to transmit |
| tx_valid | input | 1 | tx_data is valid |
| tx_ready | output | 1 | Holding register empty |
| rx_data | output | 32 | Received slot |
| rx_err | output | 4 | Per-byte error flags of the received slot |
| rx_valid | output | 1 | Received slot available |
| rx_ready | input | 1 | Consumer takes the received slot |

## Verification
The hardest case to reach from the ports is a completed slot that lands while the previous one is still unaccepted. The bench sets this up by holding rx_ready low across two whole received slots. It then shows that the first slot is still on the outputs and that the second never appears. A second hard case is an error flag sampled at the wrong position within a byte. To catch it, the stimulus drives the inverse of the intended flag on every data position other than bit 4 of each byte, so any shifted sampling point flips a flag. The zero-fill case is reached by capturing a period during which no word was offered.

// File: rtl/subband_pkg.sv
package subband_pkg;

    localparam int RATE_W = 2;
    localparam int DIV_W  = 5;

    typedef enum logic [RATE_W-1:0] {
        RATE_FAST   = 2'd0,
        RATE_HIGH   = 2'd1,
        RATE_MID    = 2'd2,
        RATE_LOW    = 2'd3
    } rate_e;

    // Largest divider value; parking here makes the first encode cycle wrap.
    localparam logic [DIV_W-1:0] DIV_PARK = 5'd23;

    function automatic logic [DIV_W-1:0] bclk_period(input rate_e rate);
        case (rate)
            RATE_FAST: return 5'd8;
            RATE_HIGH: return 5'd12;
            RATE_MID:  return 5'd16;
            default:   return 5'd24;
        endcase
    endfunction

endpackage

// File: rtl/subband_bitclk_gen.sv
module subband_bitclk_gen
    import subband_pkg::*;
#(
    parameter int POS_HALF = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        enc_i,
    input  logic [RATE_W-1:0]           rate_i,
    output logic                        adv_o,
    output logic [$clog2(2*POS_HALF)-1:0] pos_next_o,
    output logic                        bclk_o,
    output logic                        ws_o
);

    localparam int POS_W = $clog2(2*POS_HALF);

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic [POS_W-1:0] pos;
        logic             bclk;
        logic             ws;
    } gen_state_t;

    localparam gen_state_t GEN_RST = '{div: DIV_PARK, pos: '1, bclk: 1'b1, ws: 1'b1};

    gen_state_t s_d, s_q;
    logic [DIV_W-1:0] per;
    logic             adv;

    always_comb begin
        s_d = s_q;
        adv = 1'b0;
        per = bclk_period(rate_e'(rate_i));
        if (!enc_i) begin
            s_d = GEN_RST;
        end else if (s_q.div >= per - 1'b1) begin
            adv      = 1'b1;
            s_d.div  = '0;
            s_d.pos  = s_q.pos + 1'b1;
            s_d.bclk = 1'b0;
            s_d.ws   = s_d.pos[POS_W-1];
        end else begin
            s_d.div = s_q.div + 1'b1;
            if (s_q.div + 1'b1 == (per >> 1)) begin
                s_d.bclk = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= GEN_RST;
        end else begin
            s_q <= s_d;
        end
    end

    assign adv_o      = adv;
    assign pos_next_o = s_q.pos + 1'b1;
    assign bclk_o     = s_q.bclk;
    assign ws_o       = s_q.ws;

endmodule

// File: rtl/subband_slot_tx.sv
module subband_slot_tx #(
    parameter int DATA_HALF = 16,
    parameter int POS_HALF  = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          enc_i,
    input  logic                          adv_i,
    input  logic [$clog2(2*POS_HALF)-1:0] pos_next_i,
    input  logic [2*DATA_HALF-1:0]        tx_data_i,
    input  logic                          tx_valid_i,
    output logic                          tx_ready_o,
    output logic                          sd_o
);

    localparam int SLOT_W = 2 * DATA_HALF;
    localparam int POS_W  = $clog2(2*POS_HALF);
    localparam int CNT_W  = POS_W - 1;
    localparam int IDX_W  = $clog2(SLOT_W);
    localparam logic [CNT_W-1:0] OFF_LAST = CNT_W'(DATA_HALF);

    typedef struct packed {
        logic [SLOT_W-1:0] hold;
        logic              full;
        logic [SLOT_W-1:0] slot;
        logic              sd;
    } tx_state_t;

    tx_state_t s_d, s_q;
    logic [CNT_W-1:0] off;
    logic [IDX_W-1:0] idx;

    always_comb begin
        s_d = s_q;
        off = pos_next_i[CNT_W-1:0];
        idx = IDX_W'(pos_next_i[POS_W-1] ? DATA_HALF : 0) + IDX_W'(off - 1'b1);

        // Start of a word-select period: take the held word or send zeros.
        if (adv_i && pos_next_i == '0) begin
            s_d.slot = s_q.full ? s_q.hold : '0;
            s_d.full = 1'b0;
        end
        if (tx_valid_i && !s_q.full) begin
            s_d.hold = tx_data_i;
            s_d.full = 1'b1;
        end

        if (!enc_i) begin
            s_d.sd = 1'b0;
        end else if (adv_i) begin
            if (off != '0 && off <= OFF_LAST) begin
                s_d.sd = s_q.slot[idx];
            end else begin
                s_d.sd = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign tx_ready_o = !s_q.full;
    assign sd_o       = s_q.sd;

endmodule

// File: rtl/subband_slot_rx.sv
module subband_slot_rx #(
    parameter int DATA_HALF   = 16,
    parameter int POS_HALF    = 32,
    parameter int BYTE_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          enc_i,
    input  logic                          bclk_i,
    input  logic                          ws_i,
    input  logic                          sd_i,
    input  logic                          err_i,
    output logic [2*DATA_HALF-1:0]        rx_data_o,
    output logic [2*DATA_HALF/BYTE_W-1:0] rx_err_o,
    output logic                          rx_valid_o,
    input  logic                          rx_ready_i
);

    localparam int SLOT_W   = 2 * DATA_HALF;
    localparam int ERR_N    = SLOT_W / BYTE_W;
    localparam int CNT_W    = $clog2(POS_HALF);
    localparam int IDX_W    = $clog2(SLOT_W);
    localparam int BYTE_LSB = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0]    CNT_MAX  = CNT_W'(POS_HALF - 1);
    localparam logic [CNT_W-1:0]    OFF_LAST = CNT_W'(DATA_HALF);
    localparam logic [BYTE_LSB-1:0] MID_BIT  = BYTE_LSB'(BYTE_W / 2);
    localparam logic [IDX_W-1:0]    IDX_LAST = IDX_W'(SLOT_W - 1);

    // Sample vector order: {bit clock, word select, data, error}
    typedef struct packed {
        logic [SYNC_STAGES-1:0][3:0] sync;
        logic                        bclk_prev;
        logic                        ws_prev;
        logic [CNT_W-1:0]            cnt;
        logic                        low_seen;
        logic [SLOT_W-1:0]           shreg;
        logic [ERR_N-1:0]            errs;
        logic [SLOT_W-1:0]           out_data;
        logic [ERR_N-1:0]            out_err;
        logic                        out_valid;
    } rx_state_t;

    localparam rx_state_t RX_RST = '{
        sync: '0, bclk_prev: 1'b0, ws_prev: 1'b1, cnt: '0, low_seen: 1'b0,
        shreg: '0, errs: '0, out_data: '0, out_err: '0, out_valid: 1'b0
    };

    rx_state_t s_d, s_q;
    logic [3:0]       smp;
    logic [CNT_W-1:0] cnt_n;
    logic [IDX_W-1:0] idx;
    logic             pending;

    always_comb begin
        s_d   = s_q;
        cnt_n = s_q.cnt;
        idx   = '0;
        for (int i = SYNC_STAGES - 1; i > 0; i--) begin
            s_d.sync[i] = s_q.sync[i-1];
        end
        s_d.sync[0]   = {bclk_i, ws_i, sd_i, err_i};
        smp           = s_q.sync[SYNC_STAGES-1];
        s_d.bclk_prev = smp[3];
        pending       = s_q.out_valid && !rx_ready_i;

        if (s_q.out_valid && rx_ready_i) begin
            s_d.out_valid = 1'b0;
        end

        if (!enc_i && smp[3] && !s_q.bclk_prev) begin
            s_d.ws_prev = smp[2];
            if (smp[2] != s_q.ws_prev) begin
                cnt_n = '0;
                if (!smp[2]) begin
                    s_d.low_seen = 1'b1;
                end
            end else if (s_q.cnt != CNT_MAX) begin
                cnt_n = s_q.cnt + 1'b1;
            end
            s_d.cnt = cnt_n;

            if (cnt_n != '0 && cnt_n <= OFF_LAST) begin
                idx = IDX_W'(smp[2] ? DATA_HALF : 0) + IDX_W'(cnt_n - 1'b1);
                s_d.shreg[idx] = smp[1];
                if (idx[BYTE_LSB-1:0] == MID_BIT) begin
                    s_d.errs[idx[IDX_W-1:BYTE_LSB]] = smp[0];
                end
                if (idx == IDX_LAST) begin
                    if (s_q.low_seen && !pending) begin
                        s_d.out_data  = s_d.shreg;
                        s_d.out_err   = s_d.errs;
                        s_d.out_valid = 1'b1;
                    end
                    s_d.low_seen = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= RX_RST;
        end else begin
            s_q <= s_d;
        end
    end

    assign rx_data_o  = s_q.out_data;
    assign rx_err_o   = s_q.out_err;
    assign rx_valid_o = s_q.out_valid;

endmodule

// File: rtl/subband_serial_port.sv
module subband_serial_port
    import subband_pkg::*;
#(
    parameter int DATA_HALF   = 16,
    parameter int POS_HALF    = 32,
    parameter int BYTE_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          enc_mode,
    input  logic                          dir_hold,
    input  logic [RATE_W-1:0]             rate_sel,
    input  logic                          sb_bclk_i,
    input  logic                          sb_ws_i,
    input  logic                          sb_sd_i,
    input  logic                          sb_err_i,
    output logic                          sb_bclk_o,
    output logic                          sb_ws_o,
    output logic                          sb_sd_o,
    output logic                          drv_en_o,
    input  logic [2*DATA_HALF-1:0]        tx_data,
    input  logic                          tx_valid,
    output logic                          tx_ready,
    output logic [2*DATA_HALF-1:0]        rx_data,
    output logic [2*DATA_HALF/BYTE_W-1:0] rx_err,
    output logic                          rx_valid,
    input  logic                          rx_ready
);

    localparam int POS_W = $clog2(2*POS_HALF);

    logic             adv;
    logic [POS_W-1:0] pos_next;

    subband_bitclk_gen #(
        .POS_HALF (POS_HALF)
    ) gen_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .enc_i      (enc_mode),
        .rate_i     (rate_sel),
        .adv_o      (adv),
        .pos_next_o (pos_next),
        .bclk_o     (sb_bclk_o),
        .ws_o       (sb_ws_o)
    );

    subband_slot_tx #(
        .DATA_HALF (DATA_HALF),
        .POS_HALF  (POS_HALF)
    ) tx_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .enc_i      (enc_mode),
        .adv_i      (adv),
        .pos_next_i (pos_next),
        .tx_data_i  (tx_data),
        .tx_valid_i (tx_valid),
        .tx_ready_o (tx_ready),
        .sd_o       (sb_sd_o)
    );

    subband_slot_rx #(
        .DATA_HALF   (DATA_HALF),
        .POS_HALF    (POS_HALF),
        .BYTE_W      (BYTE_W),
        .SYNC_STAGES (SYNC_STAGES)
    ) rx_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .enc_i      (enc_mode),
        .bclk_i     (sb_bclk_i),
        .ws_i       (sb_ws_i),
        .sd_i       (sb_sd_i),
        .err_i      (sb_err_i),
        .rx_data_o  (rx_data),
        .rx_err_o   (rx_err),
        .rx_valid_o (rx_valid),
        .rx_ready_i (rx_ready)
    );

    assign drv_en_o = enc_mode && !dir_hold;

endmodule

// File: rtl/subband_port_chk.sv
module subband_port_chk #(
    parameter int DATA_HALF = 16,
    parameter int BYTE_W    = 8
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          enc_mode,
    input logic                          sb_bclk_o,
    input logic                          sb_ws_o,
    input logic                          sb_sd_o,
    input logic                          tx_valid,
    input logic                          tx_ready,
    input logic [2*DATA_HALF-1:0]        rx_data,
    input logic [2*DATA_HALF/BYTE_W-1:0] rx_err,
    input logic                          rx_valid,
    input logic                          rx_ready
);

    AST_WS_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (enc_mode && $past(enc_mode) && !$stable(sb_ws_o)) |-> $fell(sb_bclk_o)); // R3

    AST_SD_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (enc_mode && $past(enc_mode) && !$stable(sb_sd_o)) |-> $fell(sb_bclk_o)); // R3

    AST_HOLD_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready) |=> !tx_ready); // R5

    AST_RX_QUIET_ENC: assert property (@(posedge clk) disable iff (!rst_n)
        (enc_mode && !rx_valid) |=> !rx_valid); // R7

    AST_RX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data) && $stable(rx_err))); // R9

    AST_PARK_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
        !enc_mode |=> (sb_bclk_o && sb_ws_o && !sb_sd_o)); // R11

endmodule

bind subband_serial_port subband_port_chk #(
    .DATA_HALF (DATA_HALF),
    .BYTE_W    (BYTE_W)
) chk_i (.*);

// File: tb/subband_serial_port_tb_top.sv
module subband_serial_port_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enc_mode = 1'b0;
    logic        dir_hold = 1'b0;
    logic [1:0]  rate_sel = 2'd0;
    logic        sb_bclk_i = 1'b1;
    logic        sb_ws_i = 1'b1;
    logic        sb_sd_i = 1'b0;
    logic        sb_err_i = 1'b0;
    logic        sb_bclk_o, sb_ws_o, sb_sd_o, drv_en_o;
    logic [31:0] tx_data = '0;
    logic        tx_valid = 1'b0;
    logic        tx_ready;
    logic [31:0] rx_data;
    logic [3:0]  rx_err;
    logic        rx_valid;
    logic        rx_ready = 1'b1;

    int n_chk = 0;
    int n_bad = 0;
    int got_n = 0;
    logic [31:0] got_data = '0;
    logic [3:0]  got_err = '0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    subband_serial_port dut_i (
        .clk(clk), .rst_n(rst_n), .enc_mode(enc_mode), .dir_hold(dir_hold),
        .rate_sel(rate_sel), .sb_bclk_i(sb_bclk_i), .sb_ws_i(sb_ws_i),
        .sb_sd_i(sb_sd_i), .sb_err_i(sb_err_i), .sb_bclk_o(sb_bclk_o),
        .sb_ws_o(sb_ws_o), .sb_sd_o(sb_sd_o), .drv_en_o(drv_en_o),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .rx_data(rx_data), .rx_err(rx_err), .rx_valid(rx_valid), .rx_ready(rx_ready)
    );

    // {rate code, slot word}
    localparam logic [33:0] TX_VEC [4] = '{
        {2'd0, 32'hA5C3_0F81},
        {2'd1, 32'h8000_0001},
        {2'd2, 32'hFFFF_0000},
        {2'd3, 32'h1234_5678}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int half_of(input logic [1:0] r);
        case (r)
            2'd0: return 4;
            2'd1: return 6;
            2'd2: return 8;
            default: return 12;
        endcase
    endfunction

    always @(negedge clk) begin
        if (rst_n && rx_valid && rx_ready) begin
            got_n++;
            got_data = rx_data;
            got_err  = rx_err;
        end
    end

    task automatic push_word(input logic [31:0] w);
        while (!tx_ready) @(negedge clk);
        tx_data  = w;
        tx_valid = 1'b1;
        @(negedge clk);
        tx_valid = 1'b0;
        chk("R5 ready low after accept", {31'b0, tx_ready}, 32'd0);
    endtask

    // Capture one word-select period from the master outputs.
    task automatic cap_slot(input int half, output logic [31:0] word,
                            output int layout_bad, output int per_bad);
        logic prev;
        word = '0;
        layout_bad = 0;
        per_bad = 0;
        prev = sb_ws_o;
        forever begin
            @(negedge clk);
            if (prev && !sb_ws_o) break;
            prev = sb_ws_o;
        end
        for (int p = 0; p < 64; p++) begin
            int off;
            int lo;
            int hi;
            off = p % 32;
            if (sb_ws_o !== (p >= 32)) layout_bad++;
            if (off >= 1 && off <= 16) word[(p >= 32 ? 16 : 0) + off - 1] = sb_sd_o;
            else if (sb_sd_o !== 1'b0) layout_bad++;
            lo = 0;
            while (sb_bclk_o == 1'b0) begin @(negedge clk); lo++; end
            hi = 0;
            while (sb_bclk_o == 1'b1) begin @(negedge clk); hi++; end
            if (lo != half || hi != half) per_bad++;
        end
    endtask

    // Drive one full slot as an external master; noise on unused positions.
    task automatic send_pos(input int p, input logic [31:0] w, input logic [3:0] e);
        int off;
        int idx;
        off = p % 32;
        sb_bclk_i = 1'b0;
        sb_ws_i   = (p >= 32);
        if (off >= 1 && off <= 16) begin
            idx      = (p >= 32 ? 16 : 0) + off - 1;
            sb_sd_i  = w[idx];
            sb_err_i = (idx % 8 == 4) ? e[idx/8] : ~e[idx/8];
        end else begin
            sb_sd_i  = 1'b1;
            sb_err_i = 1'b1;
        end
        repeat (4) @(negedge clk);
        sb_bclk_i = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic send_slot(input logic [31:0] w, input logic [3:0] e);
        for (int p = 0; p < 64; p++) send_pos(p, w, e);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] w;
        int lb;
        int pb;
        int n0;

        repeat (4) @(negedge clk);
        // R1 reset state
        chk("R1 bclk", {31'b0, sb_bclk_o}, 32'd1);
        chk("R1 ws", {31'b0, sb_ws_o}, 32'd1);
        chk("R1 sd", {31'b0, sb_sd_o}, 32'd0);
        chk("R1 tx_ready", {31'b0, tx_ready}, 32'd1);
        chk("R1 rx_valid", {31'b0, rx_valid}, 32'd0);
        chk("R1 drv_en", {31'b0, drv_en_o}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R6 driver enable
        enc_mode = 1'b1;
        dir_hold = 1'b1;
        @(negedge clk);
        chk("R6 held in encode", {31'b0, drv_en_o}, 32'd0);
        dir_hold = 1'b0;
        @(negedge clk);
        chk("R6 driving in encode", {31'b0, drv_en_o}, 32'd1);

        // Table-driven master transmit
        foreach (TX_VEC[i]) begin
            rate_sel = TX_VEC[i][33:32];
            push_word(TX_VEC[i][31:0]);
            cap_slot(half_of(TX_VEC[i][33:32]), w, lb, pb);
            chk($sformatf("R4 word vec%0d", i), w, TX_VEC[i][31:0]);
            chk($sformatf("R3 layout vec%0d", i), lb, 32'd0);
            chk($sformatf("R2 period vec%0d", i), pb, 32'd0);
            chk($sformatf("R5 ready after load vec%0d", i), {31'b0, tx_ready}, 32'd1);
        end

        // R5 empty holding register gives a zero slot
        cap_slot(half_of(rate_sel), w, lb, pb);
        chk("R5 zero slot", w, 32'd0);
        chk("R4 zero slot layout", lb, 32'd0);

        // R11 parked outputs in decode
        enc_mode = 1'b0;
        repeat (3) @(negedge clk);
        chk("R11 bclk parked", {31'b0, sb_bclk_o}, 32'd1);
        chk("R11 ws parked", {31'b0, sb_ws_o}, 32'd1);
        chk("R11 sd parked", {31'b0, sb_sd_o}, 32'd0);
        chk("R6 off in decode", {31'b0, drv_en_o}, 32'd0);

        // R10 high half with no low-half start
        for (int p = 32; p < 64; p++) send_pos(p, 32'hFFFF_FFFF, 4'hF);
        repeat (10) @(negedge clk);
        chk("R10 no partial slot", got_n, 32'd0);

        // R7/R8 full slots
        n0 = got_n;
        send_slot(32'hC001_D00D, 4'b0101);
        chk("R7 slot count", got_n - n0, 32'd1);
        chk("R7 slot data", got_data, 32'hC001_D00D);
        chk("R8 error flags", {28'b0, got_err}, 32'h5);
        send_slot(32'h0F0F_3C96, 4'b1010);
        chk("R7 second slot data", got_data, 32'h0F0F_3C96);
        chk("R8 second flags", {28'b0, got_err}, 32'hA);

        // R9 hold and discard
        rx_ready = 1'b0;
        n0 = got_n;
        send_slot(32'h1111_2222, 4'b0011);
        chk("R9 valid held", {31'b0, rx_valid}, 32'd1);
        chk("R9 data held", rx_data, 32'h1111_2222);
        send_slot(32'h3333_4444, 4'b1100);
        chk("R9 later slot discarded", rx_data, 32'h1111_2222);
        chk("R9 flags kept", {28'b0, rx_err}, 32'h3);
        rx_ready = 1'b1;
        repeat (3) @(negedge clk);
        chk("R9 one delivery", got_n - n0, 32'd1);
        chk("R9 delivered data", got_data, 32'h1111_2222);
        chk("R9 valid cleared", {31'b0, rx_valid}, 32'd0);
        send_slot(32'hDEAD_BEEF, 4'b1001);
        chk("R7 after drain", got_data, 32'hDEAD_BEEF);
        chk("R8 after drain", {28'b0, got_err}, 32'h9);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule